// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers a parameterised set of level-sensitive peripheral interrupt lines and drives one interrupt request line toward each CPU. Every CPU owns a private register bank. Each bank holds one enable word per group of 32 sources, plus an equally sized set of read-only status words. A source reaches a CPU only while its bit is set in that CPU's enable word, so any peripheral can be steered to any CPU, or to several CPUs at once.

There is no priority encoder, vector register or queue. Software reads the status words of its own bank to find the active sources. It changes an enable word by writing the whole word. Inputs pass through a two-flop synchronizer before they reach any logic. Each CPU output is a registered OR of its masked sources.

The register bus is a single-cycle word-addressed port. A write takes effect at the clock edge that samples it. Read data appears on the cycle after the read strobe.

Top module: `irq_fanout_ctrl`

## Requirements
- R1: The number of sources NUM_SRC is 32, 64 or 128, which gives NUM_SRC/32 word pairs per bank. An enable or status word index at or above NUM_SRC/32 reads zero, and writes to it are ignored.
- R2: After reset every enable word is zero and every bit of cpu_irq is low.
- R3: Enable word w of CPU c is at word address c*8 + w (bit 2 of the address is clear). A write replaces the whole word, and a read returns the last value written.
- R4: Status word w of CPU c is at word address c*8 + 4 + w. It reads the synchronized input bits 32*w..32*w+31 ANDed with that CPU's enable word w. bus_rdata shows the result one cycle after bus_rd.
- R5: Writes to a status word address change no enable word and no status value.
- R6: cpu_irq[c] is high when any synchronized source is enabled in bank c. A change on irq_in shows on cpu_irq three clock edges later: two synchronizer stages, then the output register.
- R7: A write that clears the enabling bit drops cpu_irq[c] one edge after the write edge, even if another disabled source rises in the same cycle.
- R8: A write to one CPU's bank leaves the enables and the output of every other CPU unchanged.
- R9: Bank indexes at or above NUM_CPU read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Asynchronous level interrupt sources |
| bus_addr | input | ADDR_W | Word address: bank in [ADDR_W-1:3], status select in [2], word index in [1:0] |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd, zero otherwise |
| cpu_irq | output | NUM_CPU | One interrupt request per CPU |

## Verification
Two functions can meet in one cycle. An enable-word write that disables a bank, and a new source edge on a line that the same write disables. The bench drives both on one falling edge. It then expects the CPU output to fall exactly one edge later and to stay low after the new source has crossed the synchronizer. A scoreboard queue holds the expected read data, so each status or enable read is matched against the requirements at the cycle its data lands.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
   localparam int WORD_W    = 32;
   localparam int MAX_WORDS = 4;
   localparam int BANK_SPAN = 8;

   function automatic bit src_count_ok(int n);
      return (n == 32) || (n == 64) || (n == 128);
   endfunction
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("irqf_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];

   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   if (STAGES == 2) begin : g_chk
      assert_sync_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (age == 2'd2) |-> (q == $past(d, 2)));
   end
endmodule

// File: rtl/irqf_bank.sv
module irqf_bank
   import irqf_pkg::*;
#(
   parameter int NUM_SRC = 64,
   localparam int NW     = NUM_SRC / WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] lvl,
   input  logic              hit,
   input  logic              we,
   input  logic              sel_stat,
   input  logic [1:0]        word,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic              irq
);
   logic [NUM_SRC-1:0] en_flat;
   logic [NUM_SRC-1:0] masked;
   logic [WORD_W-1:0]  en_pad [MAX_WORDS];
   logic [WORD_W-1:0]  st_pad [MAX_WORDS];

   for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
      if (w < NW) begin : g_real
         logic [WORD_W-1:0] en_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               en_q <= '0;
            else if (hit && we && !sel_stat && (word == 2'(w)))
               en_q <= wdata;
         end
         assign en_flat[w*WORD_W +: WORD_W] = en_q;
         assign en_pad[w] = en_q;
         assign st_pad[w] = masked[w*WORD_W +: WORD_W];
      end else begin : g_void
         assign en_pad[w] = '0;
         assign st_pad[w] = '0;
      end
   end

   assign masked = lvl & en_flat;
   assign rdata  = sel_stat ? st_pad[word] : en_pad[word];

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |masked;
   end

   assert_status_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && we && sel_stat) |=> $stable(en_flat));
   assert_other_bank_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !hit) |=> $stable(en_flat));
   assert_no_irq_without_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_flat == '0) |=> !irq);
endmodule

// File: rtl/irq_fanout_ctrl.sv
module irq_fanout_ctrl
   import irqf_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int NUM_CPU = 2,
   parameter int ADDR_W  = 6,
   localparam int BW     = ADDR_W - 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [WORD_W-1:0]  bus_wdata,
   output logic [WORD_W-1:0]  bus_rdata,
   output logic [NUM_CPU-1:0] cpu_irq
);
   if (!src_count_ok(NUM_SRC)) begin : g_bad_src
      $error("irq_fanout_ctrl: NUM_SRC must be 32, 64 or 128");
   end
   if (NUM_CPU < 1 || ADDR_W < 4 || (2 ** BW) < NUM_CPU) begin : g_bad_map
      $error("irq_fanout_ctrl: address width too small for NUM_CPU banks");
   end

   logic [NUM_SRC-1:0] lvl;
   logic [BW-1:0]      bank_idx;
   logic               sel_stat;
   logic [1:0]         word;
   logic [WORD_W-1:0]  bank_rd [NUM_CPU];
   logic [NUM_CPU-1:0] hit;
   logic [WORD_W-1:0]  rd_mux;

   assign bank_idx = bus_addr[ADDR_W-1:3];
   assign sel_stat = bus_addr[2];
   assign word     = bus_addr[1:0];

   irqf_sync #(.W(NUM_SRC), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(lvl)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      assign hit[c] = (32'(bank_idx) == c);
      irqf_bank #(.NUM_SRC(NUM_SRC)) u_bank (
         .clk(clk), .rst_n(rst_n), .lvl(lvl), .hit(hit[c]),
         .we(bus_wr), .sel_stat(sel_stat), .word(word),
         .wdata(bus_wdata), .rdata(bank_rd[c]), .irq(cpu_irq[c])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CPU; c++)
         if (hit[c]) rd_mux = bank_rd[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
      else             bus_rdata <= '0;
   end

   assert_void_bank_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (32'(bank_idx) >= NUM_CPU)) |=> (bus_rdata == '0));
   assert_onehot_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: tb/tb_irq_fanout_ctrl.sv
`timescale 1ns/1ps
module tb_irq_fanout_ctrl;
   localparam int NS = 64;
   localparam int NC = 2;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq_in = '0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] cpu_irq;

   irq_fanout_ctrl #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
   );

   always #2.5 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [31:0] exp_q [$];
   string       tag_q [$];
   bit          pend = 1'b0;

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) pend = bus_rd;
   always @(negedge clk) begin
      if (pend) begin
         logic [31:0] e;
         string t;
         if (exp_q.size() == 0) begin
            chk(1'b0, "scoreboard empty", bus_rdata, 32'h0);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(bus_rdata == e, t, bus_rdata, e);
         end
      end
   end

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
      bus_addr = a; bus_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_irq == '0, "R2 irq low after reset", 32'(cpu_irq), 0);
      rd(6'd0, 32'h0, "R2 enable zero after reset");
      rd(6'd9, 32'h0, "R2 cpu1 enable zero after reset");

      wr(6'd0, 32'hFFFF_0000);
      rd(6'd0, 32'hFFFF_0000, "R3 cpu0 word0 readback");
      rd(6'd8, 32'h0, "R8 cpu1 word0 untouched");
      wr(6'd9, 32'h0000_00F0);
      rd(6'd9, 32'h0000_00F0, "R3 cpu1 word1 readback");
      rd(6'd1, 32'h0, "R8 cpu0 word1 untouched");

      irq_in[16] = 1'b1;
      edges(2);
      chk(cpu_irq[0] == 1'b0, "R6 not yet after two edges", 32'(cpu_irq), 0);
      edges(1);
      chk(cpu_irq[0] == 1'b1, "R6 cpu0 high after three edges", 32'(cpu_irq), 1);
      chk(cpu_irq[1] == 1'b0, "R8 cpu1 stays low", 32'(cpu_irq), 1);
      rd(6'd4, 32'h0001_0000, "R4 cpu0 status word0");
      rd(6'd12, 32'h0, "R4 cpu1 status word0 masked");

      wr(6'd4, 32'hFFFF_FFFF);
      rd(6'd0, 32'hFFFF_0000, "R5 enable unchanged by status write");
      rd(6'd4, 32'h0001_0000, "R5 status unchanged by status write");

      irq_in[36] = 1'b1;
      edges(3);
      chk(cpu_irq == 2'b11, "R6 cpu1 high from word1 source", 32'(cpu_irq), 3);
      rd(6'd13, 32'h0000_0010, "R4 cpu1 status word1");

      wr(6'd2, 32'hFFFF_FFFF);
      rd(6'd2, 32'h0, "R1 word2 absent reads zero");
      rd(6'd6, 32'h0, "R1 status word2 absent reads zero");
      wr(6'd16, 32'hFFFF_FFFF);
      rd(6'd16, 32'h0, "R9 void bank reads zero");
      chk(cpu_irq == 2'b11, "R9 void bank write keeps outputs", 32'(cpu_irq), 3);

      bus_addr = 6'd0; bus_wdata = 32'h0; bus_wr = 1'b1;
      irq_in[17] = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk(cpu_irq[0] == 1'b1, "R7 still high at write edge", 32'(cpu_irq), 3);
      edges(1);
      chk(cpu_irq[0] == 1'b0, "R7 low one edge after disable", 32'(cpu_irq), 2);
      edges(4);
      chk(cpu_irq == 2'b10, "R7 stays low after new source syncs", 32'(cpu_irq), 2);

      wr(6'd0, 32'h0000_0001);
      irq_in[0] = 1'b1;
      edges(3);
      chk(cpu_irq[0] == 1'b1, "R6 bit0 raises cpu0", 32'(cpu_irq), 3);
      irq_in[0] = 1'b0;
      edges(2);
      chk(cpu_irq[0] == 1'b1, "R6 still high two edges after drop", 32'(cpu_irq), 3);
      edges(1);
      chk(cpu_irq[0] == 1'b0, "R6 low three edges after drop", 32'(cpu_irq), 2);

      edges(2);
      chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule